// File: doc/BRIEF.md
# I2C Packet Header Sequencer

This block sits between a transmit word FIFO and an I2C bit-level engine. Software describes each bus transfer as a packet of 32-bit words. Three header words come first. They are followed by the write payload, packed four bytes to a word. The block splits that stream into its parts. It captures the payload length, the target address, the transfer direction and the per-packet control flags. It then issues a sequence of single-step commands to the bit engine: start or repeated start, address, data byte write or read, and stop.

Each command is held on the command port until the engine answers with a one-cycle response. A write response carries the acknowledge result, and a read response carries the received byte. Received bytes leave the block on a byte strobe. Three one-cycle outputs report the outcome: packet completion, the per-packet interrupt, and an aborted transfer caused by a missing acknowledge.

Top module: `i2c_pkt_sequencer`

## Requirements
- R1: After a synchronous reset the block accepts header words (`in_ready` high), issues no command (`cmd_valid` low) and holds `pkt_done`, `pkt_irq`, `nack_evt` and `rd_valid` low.
- R2: A packet starts with three header words. The address byte sent with command code 2 is `{word2[7:1], word2[19]}`, where bit 19 set means read. Command codes: 0 start, 1 repeated start, 2 address byte, 3 write byte, 4 read with ACK, 5 read with NACK, 6 stop.
- R3: Header word 1 bits [11:0] hold the byte count minus one, and exactly that many data commands (write or read) are issued.
- R4: Write payload goes out least significant byte first, four bytes per word. Unused upper bytes of the final word are discarded, and exactly ceil(count/4) payload words are consumed.
- R5: A read packet consumes no payload word. Every byte except the last is read with code 4 and the last with code 5. Each response byte appears once on `rd_byte` with `rd_valid`, in order.
- R6: With word2 bit 21 clear, a NACK answering an address or write byte stops data commands at once. The block then issues a stop, consumes the packet's remaining payload words, pulses `nack_evt` once and gives no `pkt_done`.
- R7: With word2 bit 21 set, a NACK is ignored and the packet runs to completion.
- R8: With word2 bit 16 set, the packet ends without a stop and the next packet opens with code 1. Otherwise a packet opens with code 0.
- R9: With word2 bit 18 set, the address is word2[10:1], sent as two address bytes: `{5'b11110, a[9:8], rw}`, then `a[7:0]`.
- R10: `pkt_done` is a one-cycle pulse after the last byte's response and the stop response (or, with bit 16 set, right after the last byte). `pkt_irq` pulses with it only when word2 bit 17 is set.
- R11: While `cmd_valid` is high and no response has arrived, `cmd_valid`, `cmd_op` and `cmd_byte` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | FIFO word available |
| in_word | input | 32 | FIFO word |
| in_ready | output | 1 | Block takes the word this cycle |
| cmd_valid | output | 1 | Command presented to the bit engine |
| cmd_op | output | 3 | Command code (see R2) |
| cmd_byte | output | 8 | Address or data byte of the command |
| rsp_valid | input | 1 | Engine finished the current command |
| rsp_nack | input | 1 | Address or write byte was not acknowledged |
| rsp_byte | input | 8 | Byte received by a read command |
| rd_valid | output | 1 | Received byte strobe |
| rd_byte | output | 8 | Received byte |
| pkt_done | output | 1 | Packet completed |
| pkt_irq | output | 1 | Completion interrupt for packets that request it |
| nack_evt | output | 1 | Packet aborted by a missing acknowledge |

## Verification
The bench uses the default 12-bit length field and 32-bit words, so each payload word holds four byte lanes. The chosen lengths of 1, 3, 4, 5, 6 and 8 bytes therefore cover a single byte, a partial last word, an exact word boundary and two-word packets. The bench's engine model answers either at once or one cycle late. This exercises command holding, NACK injection at a chosen command index, and back-to-back packets. A follow-on packet placed right behind each aborted or read packet shows that exactly the right number of FIFO words was drained or left alone.

// File: rtl/i2cpk_pkg.sv
package i2cpk_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);

    // Header word 2 bit positions decoded by this block
    localparam int HB_ADDR_LSB = 1;
    localparam int HB_HOLD     = 16;
    localparam int HB_IE       = 17;
    localparam int HB_TEN      = 18;
    localparam int HB_READ     = 19;
    localparam int HB_CONT     = 21;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RSTART  = 3'd1,
        OP_ADDR    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_RD_ACK  = 3'd4,
        OP_RD_NACK = 3'd5,
        OP_STOP    = 3'd6
    } op_e;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_START,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_XFER,
        ST_DRAIN,
        ST_STOP,
        ST_DONE
    } st_e;

    typedef struct packed {
        logic [9:0] addr;
        logic       rd;
        logic       ten;
        logic       hold;
        logic       cont;
        logic       ie;
    } hdr_flags_t;

    function automatic hdr_flags_t decode_flags(input logic [WORD_W-1:0] w);
        hdr_flags_t f;
        f.addr = w[HB_ADDR_LSB +: 10];
        f.rd   = w[HB_READ];
        f.ten  = w[HB_TEN];
        f.hold = w[HB_HOLD];
        f.cont = w[HB_CONT];
        f.ie   = w[HB_IE];
        return f;
    endfunction

    function automatic logic [7:0] first_addr_byte(input hdr_flags_t f);
        if (f.ten)
            return {5'b11110, f.addr[9:8], f.rd};
        else
            return {f.addr[6:0], f.rd};
    endfunction

endpackage

// File: rtl/i2cpk_hdr_capture.sv
module i2cpk_hdr_capture
    import i2cpk_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [WORD_W-1:0] word,
    output hdr_flags_t        flags,
    output logic [LEN_W-1:0]  len_m1,
    output logic              complete
);

    localparam int HDR_WORDS = 3;

    logic [1:0] idx_q;
    logic       unused_bits;

    assign unused_bits = ^word;
    assign complete    = take && (idx_q == 2'(HDR_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            len_m1 <= '0;
            flags  <= '0;
        end else if (take) begin
            idx_q <= complete ? 2'd0 : idx_q + 2'd1;
            if (idx_q == 2'd1)
                len_m1 <= word[LEN_W-1:0];
            if (idx_q == 2'd2)
                flags <= decode_flags(word);
        end
    end

    a_r2_idx_range: assert property (@(posedge clk) disable iff (rst)
        idx_q != 2'd3);

endmodule

// File: rtl/i2cpk_unpacker.sv
module i2cpk_unpacker
    import i2cpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              pop,
    input  logic              drop,
    input  logic              clr,
    output logic              valid,
    output logic [BYTE_W-1:0] byte_o
);

    logic [WORD_W-1:0] buf_q;
    logic [LANE_W-1:0] lane_q;

    assign byte_o = buf_q[{lane_q, 3'b000} +: BYTE_W];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            valid  <= 1'b0;
            lane_q <= '0;
            buf_q  <= '0;
        end else if (load) begin
            buf_q  <= word;
            lane_q <= '0;
            valid  <= 1'b1;
        end else if (pop) begin
            lane_q <= lane_q + 1'b1;
            if (drop || lane_q == LANE_W'(LANES - 1))
                valid <= 1'b0;
        end
    end

    a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop |-> valid);
    a_r4_load_empty: assert property (@(posedge clk) disable iff (rst)
        load |-> !valid);

endmodule

// File: rtl/i2c_pkt_sequencer.sv
module i2c_pkt_sequencer
    import i2cpk_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_word,
    output logic        in_ready,
    output logic        cmd_valid,
    output logic [2:0]  cmd_op,
    output logic [7:0]  cmd_byte,
    input  logic        rsp_valid,
    input  logic        rsp_nack,
    input  logic [7:0]  rsp_byte,
    output logic        rd_valid,
    output logic [7:0]  rd_byte,
    output logic        pkt_done,
    output logic        pkt_irq,
    output logic        nack_evt
);

    localparam int CNT_W = LEN_W + 1;

    st_e              st_q;
    hdr_flags_t       flags;
    logic [LEN_W-1:0] len_m1;
    logic             hdr_complete;
    logic             hdr_take;
    logic [CNT_W-1:0] bytes_left_q;
    logic [CNT_W-1:0] words_left_q;
    logic             rs_pending_q;
    logic             aborted_q;
    logic             rd_valid_q;
    logic [7:0]       rd_byte_q;
    logic             nack_q;

    logic             up_valid;
    logic [7:0]       up_byte;
    logic             up_load;
    logic             up_pop;
    logic             up_drop;
    logic             fetch;
    logic             word_take;
    logic             cmd_done;
    logic             nack_abort;
    logic             last_byte;
    op_e              op_c;

    assign hdr_take = (st_q == ST_HDR) && in_valid;

    i2cpk_hdr_capture #(.LEN_W(LEN_W)) u_hdr (
        .clk      (clk),
        .rst      (rst),
        .take     (hdr_take),
        .word     (in_word),
        .flags    (flags),
        .len_m1   (len_m1),
        .complete (hdr_complete)
    );

    assign fetch = ((st_q == ST_XFER) && !flags.rd && !up_valid && (words_left_q != '0))
                || ((st_q == ST_DRAIN) && (words_left_q != '0));
    assign in_ready  = (st_q == ST_HDR) || fetch;
    assign word_take = fetch && in_valid;
    assign up_load   = word_take && (st_q == ST_XFER);
    assign last_byte = (bytes_left_q == CNT_W'(1));

    always_comb begin
        cmd_valid = 1'b0;
        op_c      = OP_START;
        cmd_byte  = '0;
        case (st_q)
            ST_START: begin
                cmd_valid = 1'b1;
                op_c      = rs_pending_q ? OP_RSTART : OP_START;
            end
            ST_ADDR_HI: begin
                cmd_valid = 1'b1;
                op_c      = OP_ADDR;
                cmd_byte  = first_addr_byte(flags);
            end
            ST_ADDR_LO: begin
                cmd_valid = 1'b1;
                op_c      = OP_ADDR;
                cmd_byte  = flags.addr[7:0];
            end
            ST_XFER: begin
                if (flags.rd) begin
                    cmd_valid = 1'b1;
                    op_c      = last_byte ? OP_RD_NACK : OP_RD_ACK;
                end else begin
                    cmd_valid = up_valid;
                    op_c      = OP_WRITE;
                    cmd_byte  = up_byte;
                end
            end
            ST_STOP: begin
                cmd_valid = 1'b1;
                op_c      = OP_STOP;
            end
            default: ;
        endcase
    end

    assign cmd_op   = op_c;
    assign cmd_done = cmd_valid && rsp_valid;

    assign nack_abort = cmd_done && rsp_nack && !flags.cont &&
                        ((st_q == ST_ADDR_HI) || (st_q == ST_ADDR_LO) ||
                         ((st_q == ST_XFER) && !flags.rd));

    assign up_pop  = cmd_done && (st_q == ST_XFER) && !flags.rd && !nack_abort;
    assign up_drop = last_byte;

    i2cpk_unpacker u_unpack (
        .clk    (clk),
        .rst    (rst),
        .load   (up_load),
        .word   (in_word),
        .pop    (up_pop),
        .drop   (up_drop),
        .clr    (nack_abort),
        .valid  (up_valid),
        .byte_o (up_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_HDR;
            bytes_left_q <= '0;
            words_left_q <= '0;
            rs_pending_q <= 1'b0;
            aborted_q    <= 1'b0;
            rd_valid_q   <= 1'b0;
            rd_byte_q    <= '0;
            nack_q       <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            nack_q     <= nack_abort;
            if (word_take)
                words_left_q <= words_left_q - CNT_W'(1);
            case (st_q)
                ST_HDR: begin
                    if (hdr_complete) begin
                        bytes_left_q <= {1'b0, len_m1} + CNT_W'(1);
                        words_left_q <= in_word[HB_READ] ? '0 :
                            ({1'b0, len_m1} >> LANE_W) + CNT_W'(1);
                        aborted_q    <= 1'b0;
                        st_q         <= ST_START;
                    end
                end
                ST_START: begin
                    if (cmd_done) begin
                        rs_pending_q <= 1'b0;
                        st_q         <= ST_ADDR_HI;
                    end
                end
                ST_ADDR_HI: begin
                    if (nack_abort) begin
                        aborted_q <= 1'b1;
                        st_q      <= ST_DRAIN;
                    end else if (cmd_done) begin
                        st_q <= flags.ten ? ST_ADDR_LO : ST_XFER;
                    end
                end
                ST_ADDR_LO: begin
                    if (nack_abort) begin
                        aborted_q <= 1'b1;
                        st_q      <= ST_DRAIN;
                    end else if (cmd_done) begin
                        st_q <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (nack_abort) begin
                        aborted_q <= 1'b1;
                        st_q      <= ST_DRAIN;
                    end else if (cmd_done) begin
                        bytes_left_q <= bytes_left_q - CNT_W'(1);
                        if (flags.rd) begin
                            rd_valid_q <= 1'b1;
                            rd_byte_q  <= rsp_byte;
                        end
                        if (last_byte) begin
                            if (flags.hold) begin
                                rs_pending_q <= 1'b1;
                                st_q         <= ST_DONE;
                            end else begin
                                st_q <= ST_STOP;
                            end
                        end
                    end
                end
                ST_DRAIN: begin
                    if (words_left_q == '0)
                        st_q <= ST_STOP;
                end
                ST_STOP: begin
                    if (cmd_done) begin
                        rs_pending_q <= 1'b0;
                        st_q         <= aborted_q ? ST_HDR : ST_DONE;
                    end
                end
                ST_DONE: st_q <= ST_HDR;
                default: st_q <= ST_HDR;
            endcase
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_byte  = rd_byte_q;
    assign nack_evt = nack_q;
    assign pkt_done = (st_q == ST_DONE);
    assign pkt_irq  = pkt_done && flags.ie;

    a_r11_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !rsp_valid) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));
    a_r5_read_no_fetch: assert property (@(posedge clk) disable iff (rst)
        ((st_q != ST_HDR) && flags.rd) |-> !in_ready);
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        pkt_done |=> !pkt_done);
    a_r10_irq_with_done: assert property (@(posedge clk) disable iff (rst)
        pkt_irq |-> pkt_done);
    a_r6_nack_no_done: assert property (@(posedge clk) disable iff (rst)
        nack_evt |-> !pkt_done);
    a_r6_nack_single: assert property (@(posedge clk) disable iff (rst)
        nack_evt |=> !nack_evt);

endmodule

// File: tb/i2c_pkt_sequencer_tb_top.sv
module i2c_pkt_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_word;
    logic        in_ready;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [7:0]  cmd_byte;
    logic        rsp_valid;
    logic        rsp_nack;
    logic [7:0]  rsp_byte;
    logic        rd_valid;
    logic [7:0]  rd_byte;
    logic        pkt_done;
    logic        pkt_irq;
    logic        nack_evt;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] fifo_q[$];
    logic [2:0]  lg_op[$];
    logic [7:0]  lg_b[$];
    logic [2:0]  ex_op[$];
    logic [7:0]  ex_b[$];
    logic [7:0]  rd_log[$];
    logic [7:0]  rd_exp[$];
    int ncmd, nack_at, n_done, n_irq, n_nack;
    bit slow, waited, take_pend;

    always #4 clk = ~clk;

    i2c_pkt_sequencer dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_byte(cmd_byte), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
        .rsp_byte(rsp_byte), .rd_valid(rd_valid), .rd_byte(rd_byte),
        .pkt_done(pkt_done), .pkt_irq(pkt_irq), .nack_evt(nack_evt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Feeder, engine model and monitor in one negedge loop
    initial begin
        in_valid = 0; in_word = '0; rsp_valid = 0; rsp_nack = 0; rsp_byte = '0;
        take_pend = 0; waited = 0;
        forever begin
            @(negedge clk);
            if (take_pend) void'(fifo_q.pop_front());
            in_valid = (fifo_q.size() > 0);
            in_word  = in_valid ? fifo_q[0] : 32'h0;
            take_pend = in_valid && in_ready && !rst;
            rsp_valid = 0; rsp_nack = 0;
            if (cmd_valid && !rst) begin
                if (slow && !waited) waited = 1;
                else begin
                    waited = 0;
                    lg_op.push_back(cmd_op);
                    lg_b.push_back(cmd_byte);
                    rsp_nack  = (ncmd == nack_at);
                    rsp_byte  = 8'h80 + 8'(ncmd);
                    if (cmd_op == 3'd4 || cmd_op == 3'd5) rd_exp.push_back(rsp_byte);
                    ncmd++;
                    rsp_valid = 1;
                end
            end
            if (rd_valid) rd_log.push_back(rd_byte);
            if (pkt_done) n_done++;
            if (pkt_irq)  n_irq++;
            if (nack_evt) n_nack++;
        end
    end

    function automatic logic [31:0] hw0();
        return 32'h0001_0010;
    endfunction

    function automatic logic [31:0] hw2(input logic [9:0] a, input bit rd,
        input bit ten, input bit hold, input bit cont, input bit ie);
        logic [31:0] w = '0;
        w[10:1] = a; w[19] = rd; w[18] = ten; w[16] = hold; w[21] = cont; w[17] = ie;
        return w;
    endfunction

    task automatic begin_case(input int nk, input bit sl);
        lg_op.delete(); lg_b.delete(); ex_op.delete(); ex_b.delete();
        rd_log.delete(); rd_exp.delete();
        ncmd = 0; nack_at = nk; slow = sl; n_done = 0; n_irq = 0; n_nack = 0;
    endtask

    task automatic e(input logic [2:0] op, input logic [7:0] b);
        ex_op.push_back(op); ex_b.push_back(b);
    endtask

    task automatic finish_case(input string req, input int done_e, input int irq_e, input int nack_e);
        repeat (90) @(negedge clk);
        chk(lg_op.size() == ex_op.size(), {req, " command count"}, lg_op.size(), ex_op.size());
        for (int i = 0; i < ex_op.size() && i < lg_op.size(); i++) begin
            chk(lg_op[i] == ex_op[i], {req, " command code"}, lg_op[i], ex_op[i]);
            if (ex_op[i] == 3'd2 || ex_op[i] == 3'd3)
                chk(lg_b[i] == ex_b[i], {req, " command byte"}, lg_b[i], ex_b[i]);
        end
        chk(rd_log.size() == rd_exp.size(), {req, " R5 read byte count"}, rd_log.size(), rd_exp.size());
        for (int i = 0; i < rd_exp.size() && i < rd_log.size(); i++)
            chk(rd_log[i] == rd_exp[i], {req, " R5 read byte"}, rd_log[i], rd_exp[i]);
        chk(n_done == done_e, {req, " R10 pkt_done pulses"}, n_done, done_e);
        chk(n_irq == irq_e,   {req, " R10 pkt_irq pulses"}, n_irq, irq_e);
        chk(n_nack == nack_e, {req, " R6 nack_evt pulses"}, n_nack, nack_e);
        chk(fifo_q.size() == 0, {req, " R4 FIFO words left"}, fifo_q.size(), 0);
        chk(in_ready == 1'b1, {req, " back to header"}, in_ready, 1);
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1,  "R1 in_ready", in_ready, 1);
        chk(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
        chk(pkt_done == 1'b0 && pkt_irq == 1'b0, "R1 done/irq", pkt_done, 0);
        chk(nack_evt == 1'b0 && rd_valid == 1'b0, "R1 nack/rd", nack_evt, 0);
        rst = 0;
    endtask

    // R2 R3 R4 R11: 5-byte write, partial last word, slow engine
    task automatic t_write5();
        begin_case(-1, 1);
        e(0, 0); e(2, 8'hA0); e(3, 8'h11); e(3, 8'h22); e(3, 8'h33); e(3, 8'h44); e(3, 8'h55); e(6, 0);
        fifo_q.push_back(hw0()); fifo_q.push_back(32'd4);
        fifo_q.push_back(hw2(10'h50, 0, 0, 0, 0, 1));
        fifo_q.push_back(32'h4433_2211); fifo_q.push_back(32'hDDCC_BB55);
        finish_case("R4 write5", 1, 1, 0);
    endtask

    // R5 R8: 3-byte read with hold, then write opens with repeated start
    task automatic t_read_hold();
        begin_case(-1, 0);
        e(0, 0); e(2, 8'h43); e(4, 0); e(4, 0); e(5, 0);
        e(1, 0); e(2, 8'h42); e(3, 8'h9A); e(6, 0);
        fifo_q.push_back(hw0()); fifo_q.push_back(32'd2);
        fifo_q.push_back(hw2(10'h21, 1, 0, 1, 0, 0));
        fifo_q.push_back(hw0()); fifo_q.push_back(32'd0);
        fifo_q.push_back(hw2(10'h21, 0, 0, 0, 0, 1));
        fifo_q.push_back(32'hFFFF_FF9A);
        finish_case("R8 read-hold", 2, 1, 0);
    endtask

    // R6: address NACK, two payload words drained
    task automatic t_addr_nack();
        begin_case(1, 0);
        e(0, 0); e(2, 8'h66); e(6, 0);
        e(0, 0); e(2, 8'h68); e(3, 8'h77); e(6, 0);
        fifo_q.push_back(hw0()); fifo_q.push_back(32'd5);
        fifo_q.push_back(hw2(10'h33, 0, 0, 0, 0, 1));
        fifo_q.push_back(32'h0403_0201); fifo_q.push_back(32'h0807_0605);
        fifo_q.push_back(hw0()); fifo_q.push_back(32'd0);
        fifo_q.push_back(hw2(10'h34, 0, 0, 0, 0, 0));
        fifo_q.push_back(32'h0000_0077);
        finish_case("R6 addr-nack", 1, 0, 1);
    endtask

    // R7: NACK ignored when continue flag set
    task automatic t_cont();
        begin_case(2, 0);
        e(0, 0); e(2, 8'h20); e(3, 8'hA1); e(3, 8'hA2); e(3, 8'hA3); e(6, 0);
        fifo_q.push_back(hw0()); fifo_q.push_back(32'd2);
        fifo_q.push_back(hw2(10'h10, 0, 0, 0, 1, 0));
        fifo_q.push_back(32'h00A3_A2A1);
        finish_case("R7 continue", 1, 0, 0);
    endtask

    // R6: NACK on second data byte, second word drained
    task automatic t_mid_nack();
        begin_case(3, 1);
        e(0, 0); e(2, 8'h24); e(3, 8'h31); e(3, 8'h32); e(6, 0);
        e(0, 0); e(2, 8'h24); e(3, 8'h5C); e(6, 0);
        fifo_q.push_back(hw0()); fifo_q.push_back(32'd7);
        fifo_q.push_back(hw2(10'h12, 0, 0, 0, 0, 0));
        fifo_q.push_back(32'h3433_3231); fifo_q.push_back(32'h3837_3635);
        fifo_q.push_back(hw0()); fifo_q.push_back(32'd0);
        fifo_q.push_back(hw2(10'h12, 0, 0, 0, 0, 0));
        fifo_q.push_back(32'h0000_005C);
        finish_case("R6 mid-nack", 1, 0, 1);
    endtask

    // R9 R3: 10-bit address, exactly one 4-byte word, then 1-byte read
    task automatic t_ten_bit();
        begin_case(-1, 0);
        e(0, 0); e(2, 8'hF4); e(2, 8'hA5); e(3, 8'hE1); e(3, 8'hE2); e(3, 8'hE3); e(3, 8'hE4); e(6, 0);
        e(0, 0); e(2, 8'h21); e(5, 0); e(6, 0);
        fifo_q.push_back(hw0()); fifo_q.push_back(32'd3);
        fifo_q.push_back(hw2(10'h2A5, 0, 1, 0, 0, 1));
        fifo_q.push_back(32'hE4E3_E2E1);
        fifo_q.push_back(hw0()); fifo_q.push_back(32'd0);
        fifo_q.push_back(hw2(10'h10, 1, 0, 0, 0, 1));
        finish_case("R9 ten-bit", 2, 2, 0);
    endtask

    initial begin
        #(8 * 50000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1;
        nack_at = -1;
        slow = 0;
        t_reset();
        t_write5();
        t_read_hold();
        t_addr_nack();
        t_cont();
        t_mid_nack();
        t_ten_bit();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule